// File: doc/BRIEF.md
# Keypad Event Queue with Peek Access

This block buffers keypad events between a matrix scanner and a host-side command decoder. Each event is one byte. The queue is a 16-slot ring that is described by a start index and a fill length. The scanner offers events on a valid-qualified input. The host has two ways to read. A destructive pop advances the ring and returns one event. A non-destructive peek returns the slot at a chosen offset from the start index.

The pop advances the start index before it reads. As a result, the slot at the start index always holds the most recently consumed event, and a peek at offset 0 returns that stale entry. Every accepted event produces a one-cycle keypad interrupt request. An event that arrives while the ring is full produces a one-cycle overflow request instead. After an overflow the queue locks and ignores further events until the overflow is cleared.

The status and error registers live outside this block and are fed only by these request pulses. A configuration write drives `flush`, which empties the ring.

The event input has no back-pressure. `ev_valid` is taken as a transfer on every cycle in which it is high, and there is no ready signal. Events that cannot be stored are dropped and reported as described in R4 and R5. The pop side is paced by the host: each `pop_req` cycle yields exactly one `pop_valid` beat on the following cycle, and that beat cannot be stalled.

Top module: `kev_fifo`

## Requirements
- R1: After reset, `q_len` is 0 and `kp_req`, `ovf_req` and `pop_valid` are low. `q_len` always reports the fill length, which ranges over 0 to 16.
- R2: An event byte is stored and returned unchanged. Bit 7 is the press state (1 = pressed) and bits 6:0 are the key code.
- R3: An accepted event is written at slot (start + length) mod 16 and the length grows by one. `kp_req` is high for exactly the cycle after acceptance.
- R4: An event that arrives while the length is 16, with no effective pop in the same cycle, is dropped. `ovf_req` pulses on the next cycle and the queue enters the locked state.
- R5: While locked, every event is ignored and produces neither `kp_req` nor `ovf_req`. A `clr_ovf` pulse ends the lock, and events are accepted again from the following cycle.
- R6: A pop while the length is 0 or 1 changes nothing. `pop_valid` rises on the next cycle with `pop_data` = 0x00.
- R7: A pop while the length is above 1 advances start by one (mod 16) and lowers the length by one. On the next cycle `pop_data` carries the slot at the new start index.
- R8: `peek_data` is combinational. It shows the slot at (start + `peek_off`) mod 16 when `peek_off` < length, and 0x00 otherwise. Offset 0 therefore shows the last consumed event.
- R9: `flush` sets start and length to 0 on the next edge. It overrides a push in the same cycle, which is dropped without any request. A pop in the same cycle returns 0x00.
- R10: A push and an effective pop in the same cycle both take effect and the length stays the same. This includes the case where the length is 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flush | input | 1 | Empty the ring (from a configuration write) |
| clr_ovf | input | 1 | Pulse that ends the overflow lock |
| ev_valid | input | 1 | Event transfer from the scanner; no back-pressure |
| ev_data | input | 8 | Event byte: [7] press state, [6:0] key code |
| pop_req | input | 1 | Destructive read request |
| pop_valid | output | 1 | Pop result beat, one cycle after `pop_req` |
| pop_data | output | 8 | Pop result byte |
| peek_off | input | 4 | Offset from the start index for a peek |
| peek_data | output | 8 | Peek result, combinational |
| q_len | output | 5 | Current fill length |
| kp_req | output | 1 | Keypad interrupt request pulse |
| ovf_req | output | 1 | Overflow error request pulse |

## Verification
The assertions check, on every cycle, a set of local cause-and-effect rules. They confirm that the length stays within bounds, that an unlocked push into a non-full ring raises `kp_req`, that a push into a full ring raises `ovf_req`, that the lock suppresses requests, that a flush empties the ring, that an under-length pop returns zero, that a simultaneous push and pop hold the length, and that out-of-range peeks read zero. Only the bench scenarios show data ordering across the ring. These include wrap-around at every start position, the stale entry visible at offset 0, the byte returned by each pop, and the resumption of pushes after the lock is cleared.

// File: rtl/kev_pkg.sv
package kev_pkg;
  localparam int unsigned KEV_W = 8;

  typedef enum logic [1:0] {
    OP_IDLE = 2'b00,
    OP_POP  = 2'b01,
    OP_PUSH = 2'b10,
    OP_BOTH = 2'b11
  } kev_op_e;
endpackage

// File: rtl/kev_store.sv
module kev_store #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned W     = 8,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr_a,
  output logic [W-1:0]  rdata_a,
  input  logic [AW-1:0] raddr_b,
  output logic [W-1:0]  rdata_b
);
  logic [W-1:0] slot_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) slot_q[g] <= '0;
      else if (we && waddr == AW'(g)) slot_q[g] <= wdata;
    end
  end

  assign rdata_a = slot_q[raddr_a];
  assign rdata_b = slot_q[raddr_b];
endmodule

// File: rtl/kev_ctrl.sv
module kev_ctrl
  import kev_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned LW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          clr_ovf,
  input  logic          ev_valid,
  input  logic          pop_req,
  output logic [AW-1:0] start_q,
  output logic [LW-1:0] len_q,
  output logic          lock_q,
  output logic          wr_en,
  output logic [AW-1:0] wr_idx,
  output logic [AW-1:0] rd_idx,
  output logic          pop_take,
  output logic          kp_req,
  output logic          ovf_req,
  output logic          pop_valid
);
  logic    full;
  logic    ovf_now;
  kev_op_e op;

  assign full     = (len_q == LW'(DEPTH));
  assign pop_take = pop_req && !flush && (len_q > LW'(1));
  assign wr_en    = ev_valid && !flush && !lock_q && (!full || pop_take);
  assign ovf_now  = ev_valid && !flush && !lock_q && full && !pop_take;
  assign wr_idx   = start_q + len_q[AW-1:0];
  assign rd_idx   = start_q + AW'(1);
  assign op       = kev_op_e'({wr_en, pop_take});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q   <= '0;
      len_q     <= '0;
      lock_q    <= 1'b0;
      kp_req    <= 1'b0;
      ovf_req   <= 1'b0;
      pop_valid <= 1'b0;
    end else begin
      kp_req    <= wr_en;
      ovf_req   <= ovf_now;
      pop_valid <= pop_req;
      lock_q    <= clr_ovf ? 1'b0 : (lock_q | ovf_now);
      if (flush) begin
        start_q <= '0;
        len_q   <= '0;
      end else begin
        unique case (op)
          OP_PUSH: len_q <= len_q + LW'(1);
          OP_POP: begin
            start_q <= start_q + AW'(1);
            len_q   <= len_q - LW'(1);
          end
          OP_BOTH: start_q <= start_q + AW'(1);
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/kev_peek.sv
module kev_peek #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned W     = 8,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned LW   = AW + 1
) (
  input  logic [AW-1:0] start_q,
  input  logic [LW-1:0] len_q,
  input  logic [AW-1:0] off,
  output logic [AW-1:0] slot_idx,
  input  logic [W-1:0]  slot_data,
  output logic [W-1:0]  data
);
  logic in_range;

  assign slot_idx = start_q + off;
  assign in_range = ({1'b0, off} < len_q);
  assign data     = in_range ? slot_data : '0;
endmodule

// File: rtl/kev_fifo.sv
module kev_fifo
  import kev_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned LW   = AW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             clr_ovf,
  input  logic             ev_valid,
  input  logic [KEV_W-1:0] ev_data,
  input  logic             pop_req,
  output logic             pop_valid,
  output logic [KEV_W-1:0] pop_data,
  input  logic [AW-1:0]    peek_off,
  output logic [KEV_W-1:0] peek_data,
  output logic [LW-1:0]    q_len,
  output logic             kp_req,
  output logic             ovf_req
);
  logic [AW-1:0]    start_q;
  logic [LW-1:0]    len_q;
  logic             lock_q;
  logic             wr_en;
  logic             pop_take;
  logic [AW-1:0]    wr_idx;
  logic [AW-1:0]    rd_idx;
  logic [AW-1:0]    pk_idx;
  logic [KEV_W-1:0] rd_data;
  logic [KEV_W-1:0] pk_slot;

  kev_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .flush(flush), .clr_ovf(clr_ovf),
    .ev_valid(ev_valid), .pop_req(pop_req),
    .start_q(start_q), .len_q(len_q), .lock_q(lock_q),
    .wr_en(wr_en), .wr_idx(wr_idx), .rd_idx(rd_idx), .pop_take(pop_take),
    .kp_req(kp_req), .ovf_req(ovf_req), .pop_valid(pop_valid)
  );

  kev_store #(.DEPTH(DEPTH), .W(KEV_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .we(wr_en), .waddr(wr_idx), .wdata(ev_data),
    .raddr_a(rd_idx), .rdata_a(rd_data),
    .raddr_b(pk_idx), .rdata_b(pk_slot)
  );

  kev_peek #(.DEPTH(DEPTH), .W(KEV_W)) u_peek (
    .start_q(start_q), .len_q(len_q), .off(peek_off),
    .slot_idx(pk_idx), .slot_data(pk_slot), .data(peek_data)
  );

  // Pop result is captured on the same edge that advances start.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pop_data <= '0;
    else if (pop_req)  pop_data <= pop_take ? rd_data : '0;
  end

  assign q_len = len_q;
endmodule

// File: rtl/kev_chk.sv
module kev_chk #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned LW   = AW + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          flush,
  input logic          ev_valid,
  input logic          pop_req,
  input logic          pop_valid,
  input logic [7:0]    pop_data,
  input logic [AW-1:0] peek_off,
  input logic [7:0]    peek_data,
  input logic [LW-1:0] q_len,
  input logic          kp_req,
  input logic          ovf_req,
  input logic          lock
);
  a_r1_len_bound: assert property (@(posedge clk) disable iff (!rst_n)
    q_len <= LW'(DEPTH));

  a_r3_push_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && !flush && !lock && q_len < LW'(DEPTH)) |=> kp_req);

  a_r4_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && !flush && !lock && !pop_req && q_len == LW'(DEPTH))
      |=> (ovf_req && !kp_req && q_len == LW'(DEPTH)));

  a_r5_locked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    lock |=> (!kp_req && !ovf_req));

  a_r6_short_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && !ev_valid && !flush && q_len <= LW'(1))
      |=> (pop_valid && pop_data == 8'h00 && q_len == $past(q_len)));

  a_r8_peek_range: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, peek_off} >= q_len) |-> peek_data == 8'h00);

  a_r9_flush: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (q_len == '0 && !kp_req));

  a_r10_push_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && pop_req && !flush && !lock && q_len > LW'(1))
      |=> q_len == $past(q_len));
endmodule

bind kev_fifo kev_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush), .ev_valid(ev_valid),
  .pop_req(pop_req), .pop_valid(pop_valid), .pop_data(pop_data),
  .peek_off(peek_off), .peek_data(peek_data), .q_len(q_len),
  .kp_req(kp_req), .ovf_req(ovf_req), .lock(lock_q)
);

// File: tb/sim_kev_fifo.sv
module sim_kev_fifo;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       flush = 1'b0, clr_ovf = 1'b0, ev_valid = 1'b0, pop_req = 1'b0;
  logic [7:0] ev_data = 8'h00;
  logic [3:0] peek_off = 4'h0;
  logic       pop_valid, kp_req, ovf_req;
  logic [7:0] pop_data, peek_data;
  logic [4:0] q_len;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  logic [7:0] m_mem [16];
  int  m_st = 0, m_len = 0;
  bit  m_lock = 1'b0;

  always #5 clk = ~clk;

  kev_fifo u0 (
    .clk(clk), .rst_n(rst_n), .flush(flush), .clr_ovf(clr_ovf),
    .ev_valid(ev_valid), .ev_data(ev_data), .pop_req(pop_req),
    .pop_valid(pop_valid), .pop_data(pop_data), .peek_off(peek_off),
    .peek_data(peek_data), .q_len(q_len), .kp_req(kp_req), .ovf_req(ovf_req)
  );

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // One clock of stimulus; expected values follow the requirement text.
  task automatic step(bit pv, logic [7:0] pd, bit pp, bit fl, bit clr, string tag);
    bit take, acc, ovf;
    logic [7:0] exp_pop;
    @(negedge clk);
    ev_valid = pv; ev_data = pd; pop_req = pp; flush = fl; clr_ovf = clr;
    take = pp && !fl && m_len > 1;
    acc  = pv && !fl && !m_lock && (m_len < 16 || take);
    ovf  = pv && !fl && !m_lock && m_len == 16 && !take;
    exp_pop = take ? m_mem[(m_st + 1) % 16] : 8'h00;
    if (acc) m_mem[(m_st + m_len) % 16] = pd;
    if (fl) begin
      m_st = 0; m_len = 0;
    end else begin
      if (take) m_st = (m_st + 1) % 16;
      m_len = m_len + int'(acc) - int'(take);
    end
    m_lock = clr ? 1'b0 : (m_lock | ovf);
    @(posedge clk); #1;
    ev_valid = 1'b0; pop_req = 1'b0; flush = 1'b0; clr_ovf = 1'b0;
    chk(tag, "kp_req", int'(kp_req), int'(acc));
    chk(tag, "ovf_req", int'(ovf_req), int'(ovf));
    chk(tag, "q_len", int'(q_len), m_len);
    chk(tag, "pop_valid", int'(pop_valid), int'(pp));
    if (pp) chk(tag, "pop_data", int'(pop_data), int'(exp_pop));
  endtask

  task automatic peek(int off, string tag);
    peek_off = 4'(off); #1;
    chk(tag, "peek_data", int'(peek_data),
        (off < m_len) ? int'(m_mem[(m_st + off) % 16]) : 0);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) m_mem[i] = 8'h00;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1", "q_len", int'(q_len), 0);
    chk("R1", "kp_req", int'(kp_req), 0);
    chk("R1", "ovf_req", int'(ovf_req), 0);
    chk("R1", "pop_valid", int'(pop_valid), 0);
    @(negedge clk); rst_n = 1'b1;

    step(0, 8'h00, 1, 0, 0, "R6");        // pop on empty
    peek(0, "R8");
    step(1, 8'h85, 0, 0, 0, "R2");        // key 5 pressed
    peek(0, "R2");
    step(0, 8'h00, 1, 0, 0, "R6");        // pop at length 1
    for (int i = 1; i < 16; i++)
      step(1, 8'((i * 37) ^ ((i & 1) << 7)), 0, 0, 0, "R3");
    for (int o = 0; o < 16; o++) peek(o, "R8");

    step(1, 8'hEE, 0, 0, 0, "R4");        // overflow at full
    step(1, 8'hDD, 0, 0, 0, "R5");        // locked: ignored
    step(0, 8'h00, 1, 0, 0, "R7");
    step(1, 8'hCC, 0, 0, 0, "R5");        // locked, room available
    step(0, 8'h00, 0, 0, 1, "R5");        // clear lock
    step(1, 8'h3C, 0, 0, 0, "R5");        // accepted again
    step(1, 8'h3D, 1, 0, 0, "R10");       // push+pop at full
    peek(15, "R10");

    while (m_len > 1) step(0, 8'h00, 1, 0, 0, "R7");
    peek(0, "R8");
    peek(1, "R8");
    step(1, 8'h11, 1, 1, 0, "R9");        // flush beats push and pop
    peek(0, "R9");

    // Wrap sweep: start walks through every index
    for (int r = 0; r < 40; r++) begin
      step(1, 8'(r + 8'h40), 0, 0, 0, "R3");
      step(1, 8'(r ^ 8'hA5), 1, 0, 0, "R10");
      step(0, 8'h00, 1, 0, 0, "R7");
      step(1, 8'(r * 3), 0, 0, 0, "R3");
      for (int o = 0; o < 16; o++) peek(o, "R8");
    end
    step(0, 8'h00, 0, 1, 0, "R9");
    chk("R9", "q_len", int'(q_len), 0);

    done = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule